// File: doc/BRIEF.md
# Compressed-Mode Parcel Sequencer

This block sits between instruction fetch and decode. It takes a stream of 16-bit parcels over a valid/ready handshake and turns it into whole instructions, each tagged with its kind and byte address. In normal mode, two parcels in a row form one 32-bit instruction. The first parcel goes in the upper half.

A parcel whose five most significant bits match a configured major opcode switches the block into compressed mode. That parcel is passed on alone as an entry token, so that a later stage can read its eleven payload bits. After it, each parcel is emitted as one 16-bit compressed instruction. Its least significant bit says whether compressed mode goes on after it.

A redirect, for example a taken branch, abandons the current stream. It puts the block back in normal mode at a new address and drops any half-joined instruction.

Top module: `parcel_sequencer`

## Requirements
- R1: After reset the block is in normal mode with no half held. `out_valid_o` is 0 while `in_valid_i` is 0. The first instruction emitted carries address `RESET_ADDR`.
- R2: In normal mode, a first parcel that is not an entry parcel is consumed with no output (`in_ready_o`=1, `out_valid_o`=0). The next parcel is emitted together with it as kind 0. Data is {first, second}, and the address is that of the first parcel.
- R3: In normal mode with no half held, a parcel whose bits 15:11 equal `ENTRY_OP` is emitted as kind 1 with data {16'h0, parcel}. The block then enters compressed mode.
- R4: In compressed mode, each parcel is emitted alone as kind 2 with data {16'h0, parcel}. If its bit 0 is 1, compressed mode continues.
- R5: A compressed parcel with bit 0 equal to 0 ends compressed mode. The following parcel is the first half of a 32-bit instruction.
- R6: The address advances by 2 after each kind 1 or kind 2 output and by 4 after each kind 0 output.
- R7: A parcel that matches `ENTRY_OP` is not treated as an entry when it arrives in compressed mode or as the second half of a 32-bit instruction.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, `in_ready_o` is 0 and no state or address changes.
- R9: While `redir_i` is high, the block neither consumes a parcel nor emits an instruction. It then returns to normal mode at `redir_addr_i`, and any held first half is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A parcel is offered |
| in_data_i | input | PW | Parcel; bit 15 is the most significant |
| in_ready_o | output | 1 | The parcel is accepted this cycle |
| redir_i | input | 1 | Restart at a new address |
| redir_addr_i | input | AW | Byte address used on restart |
| out_valid_o | output | 1 | An instruction is offered |
| out_ready_i | input | 1 | The consumer takes the instruction |
| out_data_o | output | 2*PW | Instruction; 16-bit kinds occupy the low half |
| out_kind_o | output | 2 | 0 = 32-bit, 1 = entry token, 2 = compressed |
| out_addr_o | output | AW | Byte address of the instruction |

## Verification
A wrong mode register shows up at the first instruction output after the fault. A block stuck in compressed mode emits lone kind-2 parcels where joined 32-bit words are expected. A block stuck in normal mode swallows a parcel with no output. A stale held half appears in the upper half of the next 32-bit word. An address counter error is seen on the very next emitted instruction and stays there. The bench compares every output against its model on every cycle, so each of these faults is reported within one emission.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {K_WORD = 2'd0, K_ENTRY = 2'd1, K_HALF = 2'd2} kind_e;
  typedef enum logic [1:0] {M_FIRST = 2'd0, M_SECOND = 2'd1, M_COMP = 2'd2} mode_e;
endpackage

// File: rtl/seq_classify.sv
module seq_classify #(
  parameter int unsigned PW = 16,
  parameter int unsigned OPC_W = 5,
  parameter logic [OPC_W-1:0] ENTRY_OP = 5'b11110
) (
  input  logic [PW-1:0] parcel_i,
  output logic          is_entry_o,
  output logic          cont_o
);
  // MSB-first numbering: opcode lives in the top OPC_W bits
  assign is_entry_o = (parcel_i[PW-1 -: OPC_W] == ENTRY_OP);
  assign cont_o     = parcel_i[0];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_i,
  input  logic          in_valid_i,
  input  logic [PW-1:0] parcel_i,
  input  logic          is_entry_i,
  input  logic          cont_i,
  input  logic          out_ready_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [2*PW-1:0] out_data_o,
  output kind_e         out_kind_o
);
  mode_e         mode_q, mode_d;
  logic [PW-1:0] half_q, half_d;
  logic          absorb, take;

  always_comb begin
    absorb      = (mode_q == M_FIRST) && !is_entry_i;
    out_valid_o = in_valid_i && !redir_i && !absorb;
    in_ready_o  = !redir_i && (absorb || out_ready_i);
    take        = in_valid_i && in_ready_o;
    out_data_o  = {{PW{1'b0}}, parcel_i};
    out_kind_o  = K_HALF;
    case (mode_q)
      M_FIRST:  out_kind_o = K_ENTRY;
      M_SECOND: begin
        out_kind_o = K_WORD;
        out_data_o = {half_q, parcel_i};
      end
      default:  out_kind_o = K_HALF;
    endcase
    mode_d = mode_q;
    half_d = half_q;
    if (redir_i) begin
      mode_d = M_FIRST;
    end else if (take) begin
      case (mode_q)
        M_FIRST: begin
          if (is_entry_i) mode_d = M_COMP;
          else begin
            mode_d = M_SECOND;
            half_d = parcel_i;
          end
        end
        M_SECOND: mode_d = M_FIRST;
        default:  mode_d = cont_i ? M_COMP : M_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_FIRST;
      half_q <= '0;
    end else begin
      mode_q <= mode_d;
      half_q <= half_d;
    end
  end

  a_r8_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (mode_q == $past(mode_q)));
  a_r9_redir_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> (mode_q == M_FIRST));
  a_r3_entry_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_kind_o == K_ENTRY) |=> (mode_q == M_COMP));
  a_r5_exit_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_kind_o == K_HALF && !parcel_i[0]) |=> (mode_q == M_FIRST));
endmodule

// File: rtl/seq_addr.sv
module seq_addr #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_addr_i,
  input  logic          fire_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP_W = AW'(4);
  localparam logic [AW-1:0] STEP_H = AW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= RESET_ADDR;
    else if (redir_i) addr_o <= redir_addr_i;
    else if (fire_i)  addr_o <= addr_o + (wide_i ? STEP_W : STEP_H);
  end

  a_r9_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> (addr_o == $past(redir_addr_i)));
  a_r6_addr_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redir_i && !fire_i) |=> $stable(addr_o));
endmodule

// File: rtl/parcel_sequencer.sv
module parcel_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned OPC_W = 5,
  parameter int unsigned AW = 32,
  parameter logic [OPC_W-1:0] ENTRY_OP = 5'b11110,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [PW-1:0]   in_data_i,
  output logic            in_ready_o,
  input  logic            redir_i,
  input  logic [AW-1:0]   redir_addr_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [2*PW-1:0] out_data_o,
  output logic [1:0]      out_kind_o,
  output logic [AW-1:0]   out_addr_o
);
  logic  is_entry, cont, fire;
  kind_e kind;

  seq_classify #(.PW(PW), .OPC_W(OPC_W), .ENTRY_OP(ENTRY_OP)) u_cls (
    .parcel_i(in_data_i), .is_entry_o(is_entry), .cont_o(cont)
  );

  seq_ctrl #(.PW(PW)) u_ctrl (
    .clk_i, .rst_ni, .redir_i, .in_valid_i,
    .parcel_i(in_data_i), .is_entry_i(is_entry), .cont_i(cont),
    .out_ready_i, .in_ready_o, .out_valid_o, .out_data_o,
    .out_kind_o(kind)
  );

  assign fire       = out_valid_o && out_ready_i;
  assign out_kind_o = kind;

  seq_addr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_addr (
    .clk_i, .rst_ni, .redir_i, .redir_addr_i,
    .fire_i(fire), .wide_i(kind == K_WORD), .addr_o(out_addr_o)
  );

  a_r8_no_take_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  a_r8_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !redir_i) |=> $stable(out_addr_o));
endmodule

// File: tb/parcel_sequencer_test.sv
module parcel_sequencer_test;
  localparam int N = 20;
  localparam logic [31:0] RADDR = 32'h0000_0100;
  localparam logic [31:0] JADDR = 32'h0000_8000;

  logic        clk_i = 0, rst_ni = 0;
  logic        in_valid_i = 0, redir_i = 0, out_ready_i = 0;
  logic [15:0] in_data_i = '0;
  logic [31:0] redir_addr_i = '0;
  logic        in_ready_o, out_valid_o;
  logic [31:0] out_data_o, out_addr_o;
  logic [1:0]  out_kind_o;

  int checks = 0, errors = 0;
  logic [15:0] stream [0:N-1];

  parcel_sequencer #(.RESET_ADDR(RADDR)) uut (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ready_o, .redir_i,
    .redir_addr_i, .out_valid_o, .out_ready_i, .out_data_o, .out_kind_o, .out_addr_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int m_mode = 0;            // 0 first, 1 second, 2 compressed
    logic [15:0] m_half = '0;
    logic [31:0] m_addr = RADDR;
    int p = 0;
    bit first_emit = 1, after_exit = 0, after_redir = 0, rd_done = 0;
    stream = '{16'h1234, 16'h5678, 16'hABCD, 16'hEF01, 16'hF155, 16'h0003,
               16'hF001, 16'h2222, 16'h1111, 16'hF7FF, 16'hF000, 16'h4440,
               16'h5AA5, 16'h0C3C, 16'h9999, 16'h1357, 16'h2468, 16'hF0F1,
               16'h0001, 16'h7770};
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", {31'b0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1", {31'b0, out_valid_o}, 32'd0);
    for (int cyc = 0; cyc < 3000 && p < N; cyc++) begin
      bit v, rdy, rd, ent, absorb, e_ir, e_ov;
      logic [15:0] pc;
      logic [31:0] e_data;
      logic [1:0]  e_kind;
      string tg;
      @(negedge clk_i);
      pc  = stream[p];
      v   = ($urandom % 4) != 0;
      rdy = ($urandom % 3) != 0;
      rd  = (p == 15) && (m_mode == 1) && !rd_done;
      in_valid_i = v; in_data_i = pc; out_ready_i = rdy;
      redir_i = rd; redir_addr_i = JADDR;
      #1;
      ent = (pc[15:11] == 5'b11110);
      if (rd) begin
        chk("R9", {31'b0, in_ready_o}, 32'd0);
        chk("R9", {31'b0, out_valid_o}, 32'd0);
        m_mode = 0; m_addr = JADDR; rd_done = 1; after_redir = 1;
      end else begin
        absorb = (m_mode == 0) && !ent;
        e_ir = absorb || rdy;
        e_ov = v && !absorb;
        chk(rdy ? "R2" : "R8", {31'b0, in_ready_o}, {31'b0, e_ir});
        chk(absorb ? "R2" : "R4", {31'b0, out_valid_o}, {31'b0, e_ov});
        if (e_ov) begin
          if (m_mode == 1) begin
            e_kind = 2'd0; e_data = {m_half, pc};
            tg = after_redir ? "R9" : (ent ? "R7" : (after_exit ? "R5" : "R2"));
          end else if (m_mode == 0) begin
            e_kind = 2'd1; e_data = {16'h0, pc}; tg = "R3";
          end else begin
            e_kind = 2'd2; e_data = {16'h0, pc}; tg = ent ? "R7" : "R4";
          end
          chk(tg, out_data_o, e_data);
          chk(tg, {30'b0, out_kind_o}, {30'b0, e_kind});
          chk(first_emit ? "R1" : (after_redir ? "R9" : "R6"), out_addr_o, m_addr);
        end
        if (v && e_ir) begin
          if (m_mode == 0) begin
            if (ent) begin m_mode = 2; m_addr += 2; first_emit = 0; end
            else begin m_mode = 1; m_half = pc; end
          end else if (m_mode == 1) begin
            m_mode = 0; m_addr += 4; first_emit = 0; after_exit = 0; after_redir = 0;
          end else begin
            m_addr += 2;
            if (!pc[0]) begin m_mode = 0; after_exit = 1; end
          end
          p++;
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 0; redir_i = 0;
    #1;
    chk("R5", {31'b0, out_valid_o}, 32'd0);
    chk("R6", {30'b0, p == N, 1'b0}, 32'd2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule